// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit carries out one set-vector-length operation on a 64-bit vector-state word. From the decoded operand fields, it computes a new maximum vector length and a new current vector length. It then writes both back into the state word. It can also return a value for a general-purpose destination register and a 4-bit condition field.

The current length is chosen from a fixed priority of sources, and each source is saturated to the 7-bit range. After selection, the length is clamped to the maximum. One flag combination reuses the same encoding as a step query: in that case the state word passes through unchanged and the externally computed step value is returned instead.

Requests are accepted with a valid/ready handshake. The result appears in an output register one cycle after acceptance and is held until the consumer takes it.

Top module: `vl_cfg_unit`

## Requirements
- R1: With `ms_i` set, the new maximum length is the low 7 bits of `imm_i + 1`, so an immediate of 127 gives 0. With `ms_i` clear, the maximum length is taken from the incoming state word.
- R2: With `vs_i` clear, the current length is taken from the incoming state word. With `vs_i` set, the first matching source below is used, and each is saturated at 127:
  - `ra_val_i` when `ra_idx_i` is nonzero;
  - otherwise `imm_i + 1` when `rt_idx_i` is zero;
  - otherwise `cnt_val_i`.
- R3: A selected length greater than the new maximum length is replaced by the maximum.
- R4: The state word is numbered MSB-first (state bit 0 is word bit 63):
  - the maximum length goes to word bits 63:57;
  - the current length goes to word bits 56:50;
  - bits 49:2 pass through unchanged.
- R5: When `rt_idx_i` is nonzero, `gpr_we_o` is high, `gpr_idx_o` equals `rt_idx_i`, and `gpr_data_o` is the final current length zero-extended to 64 bits. When `rt_idx_i` is zero, `gpr_we_o` is low.
- R6: When `vs_i` or `ms_i` is set, word bit 0 (vertical-first) takes `vf_i` and word bit 1 (persistence) is cleared. Otherwise word bits 1:0 pass through.
- R7: When `vf_i`=1, `vs_i`=0 and `ms_i`=0, the state word is returned unchanged and the register result is `step_i` zero-extended, written under the rule of R5.
- R8: With `rc_i` set, `cr_we_o` is high. `cr_o[3:1]` is 3'b001 when the register result is zero and 3'b010 otherwise, and `cr_o[0]` equals `so_i`.
- R9: With `rc_i` clear, `cr_we_o` stays low.
- R10: A request is accepted when `req_valid_i` and `req_ready_o` are both high. Its result shows on the outputs with `res_valid_o` high after the next clock edge. While `res_ready_i` is low, the result is held and `req_ready_o` is low.
- R11: After reset, `res_valid_o` is low and `req_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| rt_idx_i | input | 5 | Destination register number |
| ra_idx_i | input | 5 | Source register number |
| imm_i | input | 7 | Immediate length minus one |
| vf_i | input | 1 | Vertical-first request flag |
| vs_i | input | 1 | Set-length flag |
| ms_i | input | 1 | Set-maximum flag |
| rc_i | input | 1 | Condition-record flag |
| ra_val_i | input | 64 | Value of the source register |
| cnt_val_i | input | 64 | Value of the count register |
| state_i | input | 64 | Current vector-state word |
| step_i | input | 7 | Precomputed step value |
| so_i | input | 1 | Summary-overflow flag |
| res_valid_o | output | 1 | Result valid |
| res_ready_i | input | 1 | Consumer takes the result |
| state_o | output | 64 | Updated vector-state word |
| gpr_we_o | output | 1 | Register write enable |
| gpr_idx_o | output | 5 | Register write number |
| gpr_data_o | output | 64 | Register write data |
| cr_we_o | output | 1 | Condition-field write enable |
| cr_o | output | 4 | Condition field |

## Verification
The checker assumes request fields are meaningful only in the cycle a request is accepted. It captures the step-mode flags, `rc_i`, `so_i` and `state_i` at that moment and relates the held result to them. It also assumes `res_ready_i` may drop at any time, so it checks hold behaviour under backpressure. The stimulus changes inputs only between clock edges and holds each request until it is accepted. It uses a deliberate stall to show that a second request waiting during backpressure does not disturb the pending result.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;
  typedef enum logic [1:0] {
    VL_SRC_KEEP = 2'd0,
    VL_SRC_RA   = 2'd1,
    VL_SRC_IMM  = 2'd2,
    VL_SRC_CNT  = 2'd3
  } vl_src_e;
endpackage

// File: rtl/vlcfg_len_sel.sv
module vlcfg_len_sel
  import vlcfg_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7
) (
  input  logic             vs_i,
  input  logic             ra_nz_i,
  input  logic             rt_nz_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [XLEN-1:0]  cnt_val_i,
  input  logic [LEN_W:0]   imm_p1_i,
  input  logic [LEN_W-1:0] kept_vl_i,
  output logic [LEN_W-1:0] vl_o
);
  localparam int NSRC = 3;
  localparam logic [XLEN-1:0] LEN_MAX = XLEN'((1 << LEN_W) - 1);

  vl_src_e          src;
  logic [XLEN-1:0]  raw [NSRC];
  logic [LEN_W-1:0] sat [NSRC];

  assign raw[0] = ra_val_i;
  assign raw[1] = {{(XLEN-LEN_W-1){1'b0}}, imm_p1_i};
  assign raw[2] = cnt_val_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_sat
    assign sat[g] = (raw[g] > LEN_MAX) ? LEN_MAX[LEN_W-1:0] : raw[g][LEN_W-1:0];
  end

  always_comb begin
    if (!vs_i)        src = VL_SRC_KEEP;
    else if (ra_nz_i) src = VL_SRC_RA;
    else if (!rt_nz_i) src = VL_SRC_IMM;
    else              src = VL_SRC_CNT;
  end

  always_comb begin
    unique case (src)
      VL_SRC_RA:  vl_o = sat[0];
      VL_SRC_IMM: vl_o = sat[1];
      VL_SRC_CNT: vl_o = sat[2];
      default:    vl_o = kept_vl_i;
    endcase
  end
endmodule

// File: rtl/vlcfg_cr_gen.sv
module vlcfg_cr_gen #(
  parameter int LEN_W = 7
) (
  input  logic             rc_i,
  input  logic             so_i,
  input  logic [LEN_W-1:0] res_i,
  output logic             cr_we_o,
  output logic [3:0]       cr_o
);
  logic is_zero;
  assign is_zero = (res_i == '0);
  assign cr_we_o = rc_i;
  assign cr_o    = {is_zero ? 3'b001 : 3'b010, so_i};
endmodule

// File: rtl/vl_cfg_unit.sv
module vl_cfg_unit #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7,
  parameter int REG_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [REG_W-1:0] rt_idx_i,
  input  logic [REG_W-1:0] ra_idx_i,
  input  logic [LEN_W-1:0] imm_i,
  input  logic             vf_i,
  input  logic             vs_i,
  input  logic             ms_i,
  input  logic             rc_i,
  input  logic [XLEN-1:0]  ra_val_i,
  input  logic [XLEN-1:0]  cnt_val_i,
  input  logic [XLEN-1:0]  state_i,
  input  logic [LEN_W-1:0] step_i,
  input  logic             so_i,
  output logic             res_valid_o,
  input  logic             res_ready_i,
  output logic [XLEN-1:0]  state_o,
  output logic             gpr_we_o,
  output logic [REG_W-1:0] gpr_idx_o,
  output logic [XLEN-1:0]  gpr_data_o,
  output logic             cr_we_o,
  output logic [3:0]       cr_o
);
  // MSB-first field placement: state bit 0 is word bit XLEN-1
  localparam int MVL_HI = XLEN - 1;
  localparam int MVL_LO = XLEN - LEN_W;
  localparam int VL_HI  = MVL_LO - 1;
  localparam int VL_LO  = MVL_LO - LEN_W;
  localparam int VF_BIT = 0;
  localparam int PS_BIT = 1;

  logic             accept;
  logic             step_mode, mode_wr;
  logic [LEN_W:0]   imm_p1;
  logic [LEN_W-1:0] new_mvl, sel_vl, fin_vl, res_len;
  logic [XLEN-1:0]  state_nxt;
  logic [1:0]       low_nxt;
  logic             cr_we_nxt;
  logic [3:0]       cr_nxt;

  assign accept    = req_valid_i && req_ready_o;
  assign step_mode = vf_i && !vs_i && !ms_i;
  assign mode_wr   = vs_i || ms_i;
  assign imm_p1    = {1'b0, imm_i} + 1'b1;
  assign new_mvl   = ms_i ? imm_p1[LEN_W-1:0] : state_i[MVL_HI:MVL_LO];

  vlcfg_len_sel #(.XLEN(XLEN), .LEN_W(LEN_W)) u_len_sel (
    .vs_i      (vs_i),
    .ra_nz_i   (ra_idx_i != '0),
    .rt_nz_i   (rt_idx_i != '0),
    .ra_val_i  (ra_val_i),
    .cnt_val_i (cnt_val_i),
    .imm_p1_i  (imm_p1),
    .kept_vl_i (state_i[VL_HI:VL_LO]),
    .vl_o      (sel_vl)
  );

  assign fin_vl  = (sel_vl > new_mvl) ? new_mvl : sel_vl;
  assign res_len = step_mode ? step_i : fin_vl;

  always_comb begin
    low_nxt = state_i[1:0];
    if (mode_wr) begin
      low_nxt[VF_BIT] = vf_i;
      low_nxt[PS_BIT] = 1'b0;
    end
  end

  always_comb begin
    if (step_mode) state_nxt = state_i;
    else           state_nxt = {new_mvl, fin_vl, state_i[VL_LO-1:2], low_nxt};
  end

  vlcfg_cr_gen #(.LEN_W(LEN_W)) u_cr_gen (
    .rc_i    (rc_i),
    .so_i    (so_i),
    .res_i   (res_len),
    .cr_we_o (cr_we_nxt),
    .cr_o    (cr_nxt)
  );

  assign req_ready_o = !res_valid_o || res_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      state_o     <= '0;
      gpr_we_o    <= 1'b0;
      gpr_idx_o   <= '0;
      gpr_data_o  <= '0;
      cr_we_o     <= 1'b0;
      cr_o        <= '0;
    end else if (accept) begin
      res_valid_o <= 1'b1;
      state_o     <= state_nxt;
      gpr_we_o    <= (rt_idx_i != '0);
      gpr_idx_o   <= rt_idx_i;
      gpr_data_o  <= {{(XLEN-LEN_W){1'b0}}, res_len};
      cr_we_o     <= cr_we_nxt;
      cr_o        <= cr_nxt;
    end else if (res_ready_i) begin
      res_valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vlcfg_chk.sv
module vlcfg_chk #(
  parameter int XLEN  = 64,
  parameter int LEN_W = 7,
  parameter int REG_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             vf_i,
  input logic             vs_i,
  input logic             ms_i,
  input logic             rc_i,
  input logic             so_i,
  input logic [XLEN-1:0]  state_i,
  input logic             res_valid_o,
  input logic             res_ready_i,
  input logic [XLEN-1:0]  state_o,
  input logic             gpr_we_o,
  input logic [REG_W-1:0] gpr_idx_o,
  input logic [XLEN-1:0]  gpr_data_o,
  input logic             cr_we_o,
  input logic [3:0]       cr_o
);
  localparam int MVL_LO = XLEN - LEN_W;
  localparam int VL_LO  = MVL_LO - LEN_W;

  logic            cap_step, cap_rc, cap_so;
  logic [XLEN-1:0] cap_state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_step  <= 1'b0;
      cap_rc    <= 1'b0;
      cap_so    <= 1'b0;
      cap_state <= '0;
    end else if (req_valid_i && req_ready_o) begin
      cap_step  <= vf_i && !vs_i && !ms_i;
      cap_rc    <= rc_i;
      cap_so    <= so_i;
      cap_state <= state_i;
    end
  end

  a_r3_vl_within_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !cap_step) |-> (state_o[MVL_LO-1:VL_LO] <= state_o[XLEN-1:MVL_LO]));

  a_r5_wb_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && gpr_we_o) |-> (gpr_data_o[XLEN-1:LEN_W] == '0 && gpr_idx_o != '0));

  a_r7_step_state_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && cap_step) |-> (state_o == cap_state));

  a_r8_cr_format: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && cr_we_o) |-> (cr_o[0] == cap_so && $onehot(cr_o[2:1]) && !cr_o[3]));

  a_r9_no_cr_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !cap_rc) |-> !cr_we_o);

  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(state_o) && $stable(gpr_data_o)));

  a_r10_no_accept_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |-> !req_ready_o);
endmodule

bind vl_cfg_unit vlcfg_chk #(.XLEN(XLEN), .LEN_W(LEN_W), .REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .vf_i        (vf_i),
  .vs_i        (vs_i),
  .ms_i        (ms_i),
  .rc_i        (rc_i),
  .so_i        (so_i),
  .state_i     (state_i),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .state_o     (state_o),
  .gpr_we_o    (gpr_we_o),
  .gpr_idx_o   (gpr_idx_o),
  .gpr_data_o  (gpr_data_o),
  .cr_we_o     (cr_we_o),
  .cr_o        (cr_o)
);

// File: tb/tb_vl_cfg_unit.sv
`timescale 1ns/1ps
module tb_vl_cfg_unit;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0, res_ready_i = 1'b1;
  logic [4:0]  rt_idx_i = '0, ra_idx_i = '0;
  logic [6:0]  imm_i = '0, step_i = '0;
  logic        vf_i = 0, vs_i = 0, ms_i = 0, rc_i = 0, so_i = 0;
  logic [63:0] ra_val_i = '0, cnt_val_i = '0, state_i = '0;
  logic        req_ready_o, res_valid_o, gpr_we_o, cr_we_o;
  logic [63:0] state_o, gpr_data_o;
  logic [4:0]  gpr_idx_o;
  logic [3:0]  cr_o;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  vl_cfg_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .rt_idx_i(rt_idx_i), .ra_idx_i(ra_idx_i), .imm_i(imm_i), .vf_i(vf_i), .vs_i(vs_i),
    .ms_i(ms_i), .rc_i(rc_i), .ra_val_i(ra_val_i), .cnt_val_i(cnt_val_i),
    .state_i(state_i), .step_i(step_i), .so_i(so_i), .res_valid_o(res_valid_o),
    .res_ready_i(res_ready_i), .state_o(state_o), .gpr_we_o(gpr_we_o),
    .gpr_idx_o(gpr_idx_o), .gpr_data_o(gpr_data_o), .cr_we_o(cr_we_o), .cr_o(cr_o)
  );

  localparam logic [47:0] MID = 48'hA5A5_5A5A_1234;
  localparam int N = 11;
  // stimulus
  localparam logic [4:0]  T_RT  [N] = '{4, 1, 0, 6, 6, 3, 2, 5, 0, 0, 0};
  localparam logic [4:0]  T_RA  [N] = '{3, 2, 0, 0, 0, 0, 0, 0, 0, 0, 7};
  localparam logic [6:0]  T_IMM [N] = '{15, 7, 19, 0, 0, 127, 0, 0, 0, 127, 99};
  localparam logic        T_VF  [N] = '{0, 0, 1, 0, 0, 1, 0, 1, 1, 0, 0};
  localparam logic        T_VS  [N] = '{1, 1, 1, 1, 1, 0, 0, 0, 0, 1, 1};
  localparam logic        T_MS  [N] = '{1, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0};
  localparam logic        T_RC  [N] = '{1, 1, 0, 1, 0, 1, 1, 1, 1, 0, 1};
  localparam logic        T_SO  [N] = '{0, 1, 0, 0, 0, 0, 1, 0, 1, 0, 0};
  localparam logic [63:0] T_RAV [N] = '{10, 1000, 0, 0, 0, 0, 0, 0, 0, 0, 3};
  localparam logic [63:0] T_CNT [N] = '{0, 0, 0, 33, 64'h1_0000_0000, 0, 0, 0, 0, 0, 77};
  localparam logic [6:0]  T_SMV [N] = '{50, 50, 40, 40, 100, 50, 12, 12, 20, 127, 50};
  localparam logic [6:0]  T_SVL [N] = '{50, 50, 5, 5, 5, 5, 30, 30, 3, 1, 1};
  localparam logic [6:0]  T_STP [N] = '{0, 0, 0, 0, 0, 0, 0, 9, 0, 0, 0};
  // expected
  localparam logic [6:0]  E_MVL [N] = '{16, 8, 40, 40, 100, 0, 12, 12, 20, 127, 50};
  localparam logic [6:0]  E_VL  [N] = '{10, 8, 20, 33, 100, 0, 12, 30, 3, 127, 3};
  localparam logic [1:0]  E_LOW [N] = '{0, 0, 1, 0, 0, 1, 3, 3, 3, 0, 0};
  localparam logic        E_WE  [N] = '{1, 1, 0, 1, 1, 1, 1, 1, 0, 0, 0};
  localparam logic [63:0] E_DAT [N] = '{10, 8, 0, 33, 100, 0, 12, 9, 0, 0, 0};
  localparam logic        E_CWE [N] = '{1, 1, 0, 1, 0, 1, 1, 1, 1, 0, 1};
  localparam logic [3:0]  E_CR  [N] = '{4'b0100, 4'b0101, 0, 4'b0100, 0, 4'b0010,
                                        4'b0101, 4'b0100, 4'b0011, 0, 4'b0100};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input int i);
    rt_idx_i = T_RT[i]; ra_idx_i = T_RA[i]; imm_i = T_IMM[i];
    vf_i = T_VF[i]; vs_i = T_VS[i]; ms_i = T_MS[i]; rc_i = T_RC[i]; so_i = T_SO[i];
    ra_val_i = T_RAV[i]; cnt_val_i = T_CNT[i]; step_i = T_STP[i];
    state_i = {T_SMV[i], T_SVL[i], MID, 2'b11};
  endtask

  // one accepted request, checked after the capturing edge
  task automatic run_vec(input int i);
    @(negedge clk);
    drive(i);
    req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R10 valid", 64'(res_valid_o), 64'd1);
    check("R1 R2 R3 R4 R6 R7 state", state_o, {E_MVL[i], E_VL[i], MID, E_LOW[i]});
    check("R5 we", 64'(gpr_we_o), 64'(E_WE[i]));
    if (E_WE[i]) begin
      check("R5 R7 data", gpr_data_o, E_DAT[i]);
      check("R5 idx", 64'(gpr_idx_o), 64'(T_RT[i]));
    end
    check("R8 R9 cr_we", 64'(cr_we_o), 64'(E_CWE[i]));
    if (E_CWE[i]) check("R8 cr", 64'(cr_o), 64'(E_CR[i]));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 res_valid", 64'(res_valid_o), 64'd0);
    check("R11 req_ready", 64'(req_ready_o), 64'd1);
    rst_ni = 1'b1;

    for (int i = 0; i < N; i++) run_vec(i);

    // R10: backpressure holds the pending result, blocks a second request
    @(negedge clk);
    res_ready_i = 1'b0;
    drive(0);
    req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    drive(3);
    check("R10 stall ready", 64'(req_ready_o), 64'd0);
    repeat (3) @(negedge clk);
    check("R10 held state", state_o, {E_MVL[0], E_VL[0], MID, E_LOW[0]});
    check("R10 held data", gpr_data_o, E_DAT[0]);
    check("R10 held valid", 64'(res_valid_o), 64'd1);
    res_ready_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R10 next accepted", state_o, {E_MVL[3], E_VL[3], MID, E_LOW[3]});
    @(posedge clk);
    @(negedge clk);
    check("R10 drain", 64'(res_valid_o), 64'd0);

    // R2: imm source ignored when RA number is nonzero even with rt=0
    @(negedge clk);
    drive(10);
    imm_i = 7'd0;
    req_valid_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid_i = 1'b0;
    check("R2 ra priority", 64'(state_o[56:50]), 64'd3);

    finish_run();
  end
endmodule